// File: doc/BRIEF.md
# Forwarding Store Buffer with Fence

This block sits between an in-order core's load/store port and memory. Every store the core commits goes into a small queue first. The queue then writes its entries to memory one at a time, in the order the core issued them, whenever the memory write port accepts a write. No fence is needed for this draining to happen.

A load first looks through the queue. If one or more queued stores target the same word address, the load takes its data from the youngest of them, and memory is not read. If no queued store matches, the load goes to the memory read port. It may then complete ahead of older queued stores to other addresses.

A fence holds back every later operation until the queue is empty, then pulses a completion flag. The core sees one valid/ready operation port. `op_kind` encodes the operation: 2'b00 is a load, 2'b01 is a store, and 2'b10 or 2'b11 is a fence. Memory sees a write port and a read port, each with a request/acknowledge handshake.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the queue is empty, `mem_wvalid`, `mem_rvalid`, `ld_valid` and `fence_done` are low, and `op_ready` is high.
- R2: An accepted store never writes memory directly. Memory sees it only through the write port, and memory writes occur in exactly the order the stores were accepted.
- R3: While the queue holds any entry, `mem_wvalid` is high and presents the oldest entry. Entries drain on `mem_wack` with no fence required. When the queue is empty, `mem_wvalid` is low.
- R4: A load (`op_kind`=2'b00) whose word address matches a queued store returns the data of the youngest matching store, with `ld_valid` high for one cycle in the cycle after acceptance. It issues no memory read.
- R5: A load with no matching queued store raises `mem_rvalid` with its address from the cycle after acceptance until `mem_rack`. `ld_valid` then pulses in the following cycle with the `mem_rdata` sampled at the acknowledge. This may happen while older stores to other addresses are still queued. `op_ready` is low while the read is outstanding.
- R6: While the queue holds DEPTH entries, `op_ready` is low for a store (`op_kind`=2'b01) but stays high for a load.
- R7: After a fence (`op_kind[1]`=1) is accepted, `op_ready` stays low until the queue is empty. `fence_done` then pulses for exactly one cycle, and at that time every earlier store has been written to memory. If the queue is already empty, the pulse comes in the cycle right after acceptance.
- R8: Loads observe program-order semantics: every load returns the value of the latest earlier store to its address, or the memory contents if no such store exists.
- R9: While `mem_wvalid` is high without `mem_wack`, `mem_waddr` and `mem_wdata` hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_kind | input | 2 | 00 load, 01 store, 1x fence |
| op_addr | input | AW | Word address of load or store |
| op_wdata | input | DW | Store data |
| op_ready | output | 1 | Operation accepted when high with op_valid |
| ld_valid | output | 1 | Load result valid (one-cycle pulse) |
| ld_data | output | DW | Load result |
| fence_done | output | 1 | Fence completion pulse |
| mem_wvalid | output | 1 | Memory write request |
| mem_waddr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| mem_wack | input | 1 | Memory write accepted |
| mem_rvalid | output | 1 | Memory read request |
| mem_raddr | output | AW | Memory read address |
| mem_rdata | input | DW | Memory read data, valid with mem_rack |
| mem_rack | input | 1 | Memory read acknowledge |

## Verification
A forwarded load is due exactly one cycle after the edge that accepts it. The bench drives each operation at a falling edge and checks the result at the first falling edge after acceptance, requiring that no memory read occurred. A missed load is due one cycle after the edge that carries `mem_rack`. The bench's memory model acknowledges reads after two wait cycles, and the bench polls falling edges for `ld_valid`. `fence_done` is due in the first cycle in which the fence has been accepted and the queue is empty. The bench counts the falling edges until that pulse and checks `op_ready` at each of them. Memory writes are compared, at the falling edge where the model asserts `mem_wack`, against a program-order queue that the bench keeps alongside its own sequential memory image.

// File: rtl/store_fwd_buffer.sv
`timescale 1ns/1ps
module store_fwd_buffer #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic          op_ready,
  output logic          ld_valid,
  output logic [DW-1:0] ld_data,
  output logic          fence_done,
  output logic          mem_wvalid,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_wack,
  output logic          mem_rvalid,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rack
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_FENCE} st_t;

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] cnt;
  st_t           st;
  logic [AW-1:0] rd_addr;
  logic          ld_valid_q;
  logic [DW-1:0] ld_data_q;

  logic          empty, full, is_ld, is_st, is_fn, acc, push, pop;
  logic          hit;
  logic [DW-1:0] hit_data;

  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));
  assign is_ld  = (op_kind == 2'b00);
  assign is_st  = (op_kind == 2'b01);
  assign is_fn  = op_kind[1];

  assign op_ready = (st == S_IDLE) && !(is_st && full);
  assign acc      = op_valid && op_ready;
  assign push     = acc && is_st;
  assign pop      = mem_wvalid && mem_wack;

  assign mem_wvalid = !empty;
  assign mem_waddr  = addr_q[head];
  assign mem_wdata  = data_q[head];
  assign mem_rvalid = (st == S_READ);
  assign mem_raddr  = rd_addr;
  assign fence_done = (st == S_FENCE) && empty;
  assign ld_valid   = ld_valid_q;
  assign ld_data    = ld_data_q;

  // oldest to youngest; the last match wins
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PW-1:0] j;
      j = head + PW'(i);
      if (CW'(i) < cnt && addr_q[j] == op_addr) begin
        hit      = 1'b1;
        hit_data = data_q[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail] <= op_addr;
      data_q[tail] <= op_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head       <= '0;
      tail       <= '0;
      cnt        <= '0;
      st         <= S_IDLE;
      rd_addr    <= '0;
      ld_valid_q <= 1'b0;
      ld_data_q  <= '0;
    end else begin
      ld_valid_q <= 1'b0;
      head       <= head + PW'(pop);
      tail       <= tail + PW'(push);
      cnt        <= cnt + CW'(push) - CW'(pop);
      case (st)
        S_IDLE: if (acc) begin
          if (is_ld) begin
            if (hit) begin
              ld_valid_q <= 1'b1;
              ld_data_q  <= hit_data;
            end else begin
              st      <= S_READ;
              rd_addr <= op_addr;
            end
          end else if (is_fn) begin
            st <= S_FENCE;
          end
        end
        S_READ: if (mem_rack) begin
          ld_valid_q <= 1'b1;
          ld_data_q  <= mem_rdata;
          st         <= S_IDLE;
        end
        S_FENCE: if (empty) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/store_fwd_buffer_chk.sv
`timescale 1ns/1ps
module store_fwd_buffer_chk #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [1:0]                 op_kind,
  input logic                       op_ready,
  input logic                       ld_valid,
  input logic                       fence_done,
  input logic                       mem_wvalid,
  input logic                       mem_wack,
  input logic [AW-1:0]              mem_waddr,
  input logic [DW-1:0]              mem_wdata,
  input logic                       mem_rvalid,
  input logic [$clog2(DEPTH):0]     cnt
);
  p_idle_when_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 0) |-> !mem_wvalid);

  p_drain_on_own_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 0) |-> mem_wvalid);

  p_write_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wack) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));

  p_full_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == DEPTH && op_kind == 2'b01) |-> !op_ready);

  p_fence_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |-> (cnt == 0 && !op_ready));

  p_read_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> (!op_ready && !ld_valid));
endmodule

bind store_fwd_buffer store_fwd_buffer_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .op_ready(op_ready),
  .ld_valid(ld_valid), .fence_done(fence_done), .mem_wvalid(mem_wvalid),
  .mem_wack(mem_wack), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
  .mem_rvalid(mem_rvalid), .cnt(cnt)
);

// File: tb/store_fwd_buffer_test.sv
`timescale 1ns/1ps
module store_fwd_buffer_test;
  localparam int AW = 3, DW = 8, DEPTH = 4, NW = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0;
  logic [1:0] op_kind = 2'b00;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_wdata = '0;
  logic op_ready, ld_valid, fence_done, mem_wvalid, mem_rvalid;
  logic [DW-1:0] ld_data, mem_wdata;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic mem_wack = 0, mem_rack = 0;
  logic [DW-1:0] mem_rdata = '0;

  store_fwd_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uut (.*);

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0, nreads = 0, rd_wait = 0, wmode = 0;
  bit wack_en = 0;
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] refmem [NW];
  logic [AW-1:0] qa [$];
  logic [DW-1:0] qd [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_wack = 0; mem_rack = 0; rd_wait = 0;
    end else begin
      mem_wack = wack_en && (wmode == 0 || $urandom_range(0, 1) == 1);
      if (mem_wvalid && mem_wack) begin
        if (qa.size() == 0) chk(0, "R2 unexpected write", mem_waddr, 0);
        else begin
          chk(mem_waddr == qa[0] && mem_wdata == qd[0], "R2 write order",
              {mem_waddr, mem_wdata}, {qa[0], qd[0]});
          void'(qa.pop_front()); void'(qd.pop_front());
        end
        mem[mem_waddr] = mem_wdata;
      end
      if (mem_rvalid) begin
        rd_wait++;
        if (rd_wait >= 2) begin
          mem_rack = 1; mem_rdata = mem[mem_raddr]; rd_wait = 0; nreads++;
        end else mem_rack = 0;
      end else begin
        mem_rack = 0; rd_wait = 0;
      end
    end
  end

  task automatic issue(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic [DW-1:0] got, output int lat);
    @(negedge clk); #1;
    op_valid = 1; op_kind = k; op_addr = a; op_wdata = d; #1;
    while (!op_ready) begin @(negedge clk); #2; end
    if (k == 2'b01) begin refmem[a] = d; qa.push_back(a); qd.push_back(d); end
    @(negedge clk); #1;
    op_valid = 0;
    got = '0; lat = 0;
    if (k == 2'b00) begin
      int n = 0;
      while (!ld_valid && n < 50) begin @(negedge clk); #1; n++; end
      lat = n; got = ld_data;
      chk(ld_valid, "R5 load response", 0, 1);
    end else if (k[1]) begin
      int n = 0;
      while (!fence_done && n < 400) begin
        chk(!op_ready, "R7 ready low during fence", op_ready, 0);
        @(negedge clk); #1; n++;
      end
      lat = n;
      chk(fence_done, "R7 fence completes", fence_done, 1);
      chk(qa.size() == 0, "R7 earlier stores written", qa.size(), 0);
      chk(!op_ready, "R7 ready low on done cycle", op_ready, 0);
    end
  endtask

  task automatic wait_drain();
    int n = 0;
    while (mem_wvalid && n < 400) begin @(negedge clk); #1; n++; end
  endtask

  initial begin
    #(20 * 200000);
    nerr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [DW-1:0] got;
    int lat, r0;
    for (int i = 0; i < NW; i++) begin mem[i] = DW'(8'h80 + i); refmem[i] = DW'(8'h80 + i); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(op_ready, "R1 ready", op_ready, 1);
    chk(!mem_wvalid && !mem_rvalid, "R1 ports idle", {mem_wvalid, mem_rvalid}, 0);
    chk(!ld_valid && !fence_done, "R1 no pulses", {ld_valid, fence_done}, 0);

    // R4 youngest match forwarded, no drain
    wack_en = 0;
    issue(2'b01, 3, 8'h11, got, lat);
    issue(2'b01, 5, 8'h22, got, lat);
    issue(2'b01, 3, 8'h33, got, lat);
    r0 = nreads;
    issue(2'b00, 3, 0, got, lat);
    chk(got == 8'h33, "R4 youngest data", got, 8'h33);
    chk(lat == 0, "R4 latency one cycle", lat, 0);
    chk(nreads == r0, "R4 no memory read", nreads, r0);
    chk(mem_wvalid && mem_waddr == 3 && mem_wdata == 8'h11, "R3 oldest presented",
        {mem_waddr, mem_wdata}, {3'd3, 8'h11});
    chk(mem[3] == 8'h83, "R2 memory untouched before drain", mem[3], 8'h83);

    // R5 miss goes to memory while other stores queued
    issue(2'b00, 6, 0, got, lat);
    chk(got == 8'h86, "R5 miss data", got, 8'h86);
    chk(lat >= 1 && nreads == r0 + 1, "R5 memory read issued", nreads, r0 + 1);
    chk(qa.size() == 3, "R5 stores still queued", qa.size(), 3);

    // R6 full stalls stores only
    issue(2'b01, 1, 8'h44, got, lat);
    op_kind = 2'b01; op_addr = 2; #1;
    for (int c = 0; c < 3; c++) begin
      chk(!op_ready, "R6 store stalls when full", op_ready, 0);
      @(negedge clk); #1;
    end
    op_kind = 2'b00; #1;
    chk(op_ready, "R6 load ready when full", op_ready, 1);
    wack_en = 1; wmode = 0;
    issue(2'b01, 2, 8'h55, got, lat);
    // R3 drains without a fence
    wait_drain();
    chk(!mem_wvalid && qa.size() == 0, "R3 drained", qa.size(), 0);
    chk(mem[3] == 8'h33 && mem[5] == 8'h22, "R3 memory after drain", {mem[3], mem[5]}, {8'h33, 8'h22});
    chk(mem[1] == 8'h44 && mem[2] == 8'h55, "R3 memory after drain", {mem[1], mem[2]}, {8'h44, 8'h55});

    // R7 fence with queued stores, then on empty queue
    wack_en = 0;
    for (int i = 0; i < DEPTH; i++) issue(2'b01, AW'(i), DW'(8'hC0 + i), got, lat);
    wack_en = 1; wmode = 1;
    issue(2'b10, 0, 0, got, lat);
    chk(lat > 0, "R7 fence waited", lat, 1);
    issue(2'b11, 0, 0, got, lat);
    chk(lat == 0, "R7 empty fence immediate", lat, 0);

    // R8 sweep against sequential reference
    for (int n = 0; n < 800; n++) begin
      int sel;
      logic [AW-1:0] a;
      logic [DW-1:0] e;
      if (n % 100 == 0) begin wmode = (n / 100) % 2; wack_en = ((n / 100) % 3) != 2; end
      sel = $urandom_range(0, 19);
      a = AW'($urandom_range(0, NW - 1));
      if (sel < 9) issue(2'b01, a, DW'($urandom), got, lat);
      else if (sel < 18) begin
        e = refmem[a];
        issue(2'b00, a, 0, got, lat);
        chk(got == e, "R8 load value", got, e);
      end else begin
        wack_en = 1;
        issue(2'b10, 0, 0, got, lat);
      end
    end
    wack_en = 1;
    wait_drain();
    for (int i = 0; i < NW; i++) chk(mem[i] == refmem[i], "R2 final memory", mem[i], refmem[i]);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule